// File: doc/BRIEF.md
# Host-to-ISA Byte Lane Steering Engine

This block sits between a 32-bit host data word and a 16-bit ISA-side data bus that serves both 8-bit and 16-bit devices. A host access is described by four byte enables. The block breaks it into the fewest ISA-width sub-cycles the device width allows and issues them one at a time over a request/done handshake. Read bytes returned by each sub-cycle are placed back into their own lanes of the host word.

For byte-wide sub-cycles the engine moves data between the low and high halves of the ISA bus. An odd-offset byte for a 16-bit device travels on bits 15:8. Every byte for an 8-bit device travels on bits 7:0. A separate DMA request moves one 8-bit or 16-bit item between the ISA bus and a selected lane of the host word. It reports completion on its own done line. The same datapath also serves host masters that reach 8-bit on-chip registers, which are treated as 8-bit devices.

Top module: `xbus_steer`

## Requirements
- R1: After reset `isa_req`, `host_done` and `dma_done` are low and `pci_rdata` is zero.
- R2: For a 16-bit device (`host_dev16`=1), a half of the host word with both byte enables set is moved in one 16-bit sub-cycle (`isa_wide`=1). Its offset is 0 for bits 15:0 and 2 for bits 31:16, the lower half goes first, and `isa_wdata` carries {upper byte, lower byte}.
- R3: For an 8-bit device (`host_dev16`=0), each enabled byte gets its own sub-cycle in ascending offset order (0 to 3). The byte travels on `isa_wdata[7:0]` with bits 15:8 zero, and read data is taken from `isa_rdata[7:0]`.
- R4: A byte whose enable is clear produces no sub-cycle, and on reads its lane of `pci_rdata` is zero.
- R5: For a 16-bit device, a half with only one byte enabled is moved in an 8-bit sub-cycle (`isa_wide`=0). An odd-offset byte uses bits 15:8 for both directions, with bits 7:0 zero on writes. An even-offset byte uses bits 7:0, with bits 15:8 zero on writes.
- R6: On reads, the byte at offset k lands in `pci_rdata[8k+7:8k]`. The assembled word is valid while the done pulse is high and holds until the next request is accepted.
- R7: `isa_req` stays high with `isa_addr` and `isa_wide` unchanged until the edge that samples `isa_done` high. The next sub-cycle, if any, is presented in the following cycle.
- R8: `host_done` is high for exactly one cycle, in the cycle after the edge that samples the last `isa_done`. With all byte enables clear it comes in the cycle after acceptance, and no sub-cycle is issued.
- R9: A DMA request gives exactly one sub-cycle with `isa_dma`=1. With `dma_wide`=1 it is a 16-bit sub-cycle on the half chosen by `dma_lane[1]` (offset 0 or 2). Otherwise it is an 8-bit sub-cycle at offset `dma_lane` on bits 7:0. It writes the device (data from `host_wdata`) when `dma_to_pci`=0 and reads into `pci_rdata` when it is 1. Completion is signalled on `dma_done` only.
- R10: When `host_req` and `dma_req` are both high in the idle state, the DMA item is served first. The held host request is then served afterwards with its normal sub-cycle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, held until `host_done` |
| host_wr | input | 1 | 1 = host write to device, 0 = read |
| host_dev16 | input | 1 | 1 = target is a 16-bit device, 0 = 8-bit device |
| host_be | input | 4 | Byte enables of the host word |
| host_wdata | input | 32 | Host data word (write data for host and DMA) |
| host_done | output | 1 | One-cycle completion of a host request |
| pci_rdata | output | 32 | Assembled read word |
| dma_req | input | 1 | DMA request, held until `dma_done` |
| dma_wide | input | 1 | 1 = 16-bit DMA item, 0 = 8-bit |
| dma_to_pci | input | 1 | 1 = device to host word, 0 = host word to device |
| dma_lane | input | 2 | Byte lane (8-bit) or half select in bit 1 (16-bit) |
| dma_done | output | 1 | One-cycle completion of a DMA item |
| isa_req | output | 1 | ISA sub-cycle request, held until `isa_done` |
| isa_wr | output | 1 | Sub-cycle direction, 1 = write |
| isa_dma | output | 1 | Sub-cycle belongs to a DMA item |
| isa_wide | output | 1 | 1 = 16-bit sub-cycle, 0 = 8-bit |
| isa_addr | output | 2 | Byte offset of the sub-cycle within the host word |
| isa_wdata | output | 16 | ISA write data |
| isa_rdata | input | 16 | ISA read data, sampled with `isa_done` |
| isa_done | input | 1 | One-cycle completion of the current sub-cycle |

## Verification
The two functions that can collide are the host split sequence and the DMA item. Both requests may be raised in the same idle cycle, and only one can own the ISA side. The bench raises both requests on the same edge, over several byte-enable and device-width mixes. It then judges the outcome at the ports: the first sub-cycle must carry the DMA flag and the DMA lane, `dma_done` must arrive before `host_done`, and the host's full sub-cycle list and assembled read word must still match the arithmetic expectation.

// File: rtl/xbus_steer_pkg.sv
package xbus_steer_pkg;

    localparam int unsigned HOST_BYTES = 4;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ISA_W      = 16;
    localparam int unsigned LANE_W     = $clog2(HOST_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic wr;
        logic dev16;
        logic dma;
    } xfer_attr_t;

    // Byte mask covered by a single DMA item.
    function automatic logic [HOST_BYTES-1:0] dma_mask(input logic wide,
                                                       input logic [LANE_W-1:0] lane);
        logic [HOST_BYTES-1:0] m;
        m = '0;
        if (wide) begin
            m[{lane[LANE_W-1:1], 1'b0}] = 1'b1;
            m[{lane[LANE_W-1:1], 1'b1}] = 1'b1;
        end else begin
            m[lane] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/xbus_steer_pick.sv
module xbus_steer_pick
    import xbus_steer_pkg::*;
#(
    parameter int unsigned NB = HOST_BYTES,
    localparam int unsigned OW = $clog2(NB)
) (
    input  logic [NB-1:0] pend,
    input  logic          dev16,
    output logic [OW-1:0] off,
    output logic          wide,
    output logic [NB-1:0] take
);

    logic [OW-1:0] pair_hi;

    always_comb begin
        off = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (pend[i]) off = OW'(i);
        end
    end

    assign pair_hi = {off[OW-1:1], 1'b1};
    assign wide    = dev16 && !off[0] && pend[pair_hi];

    always_comb begin
        take      = '0;
        take[off] = 1'b1;
        if (wide) take[pair_hi] = 1'b1;
    end

endmodule

// File: rtl/xbus_steer_lanes.sv
module xbus_steer_lanes
    import xbus_steer_pkg::*;
#(
    parameter int unsigned NB = HOST_BYTES,
    localparam int unsigned OW = $clog2(NB),
    localparam int unsigned DW = NB * BYTE_W
) (
    input  logic [DW-1:0]    wdata,
    input  logic [OW-1:0]    off,
    input  logic             wide,
    input  logic             dev16,
    input  logic [ISA_W-1:0] isa_rdata,
    input  logic [DW-1:0]    acc,
    output logic [ISA_W-1:0] isa_wdata,
    output logic [DW-1:0]    acc_nxt
);

    logic [OW-1:0]     pair_hi;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic              odd_on_high;
    logic [BYTE_W-1:0] rd_first;

    assign pair_hi     = {off[OW-1:1], 1'b1};
    assign lo_byte     = wdata[{off, 3'b000} +: BYTE_W];
    assign hi_byte     = wdata[{pair_hi, 3'b000} +: BYTE_W];
    assign odd_on_high = dev16 && !wide && off[0];

    // Outbound: pick the half of the ISA bus each byte travels on.
    always_comb begin
        if (wide)             isa_wdata = {hi_byte, lo_byte};
        else if (odd_on_high) isa_wdata = {lo_byte, {BYTE_W{1'b0}}};
        else                  isa_wdata = {{BYTE_W{1'b0}}, lo_byte};
    end

    // Inbound: gather returned bytes into their host lanes.
    assign rd_first = odd_on_high ? isa_rdata[ISA_W-1 -: BYTE_W] : isa_rdata[BYTE_W-1:0];

    always_comb begin
        acc_nxt = acc;
        acc_nxt[{off, 3'b000} +: BYTE_W] = rd_first;
        if (wide) acc_nxt[{pair_hi, 3'b000} +: BYTE_W] = isa_rdata[ISA_W-1 -: BYTE_W];
    end

endmodule

// File: rtl/xbus_steer_seq.sv
module xbus_steer_seq
    import xbus_steer_pkg::*;
#(
    parameter int unsigned NB = HOST_BYTES,
    localparam int unsigned OW = $clog2(NB),
    localparam int unsigned DW = NB * BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic          host_dev16,
    input  logic [NB-1:0] host_be,
    input  logic          dma_req,
    input  logic          dma_wide,
    input  logic          dma_to_pci,
    input  logic [OW-1:0] dma_lane,
    input  logic [DW-1:0] wdata_in,
    input  logic          isa_done,
    input  logic [NB-1:0] take,
    input  logic [DW-1:0] acc_nxt,
    output seq_state_e    state,
    output logic [NB-1:0] pend,
    output xfer_attr_t    attr,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] acc
);

    logic [NB-1:0] pend_left;

    assign pend_left = pend & ~take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pend    <= '0;
            attr    <= '0;
            wdata_q <= '0;
            acc     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (dma_req) begin
                        pend    <= dma_mask(dma_wide, dma_lane);
                        attr    <= '{wr: !dma_to_pci, dev16: dma_wide, dma: 1'b1};
                        wdata_q <= wdata_in;
                        acc     <= '0;
                        state   <= ST_RUN;
                    end else if (host_req) begin
                        pend    <= host_be;
                        attr    <= '{wr: host_wr, dev16: host_dev16, dma: 1'b0};
                        wdata_q <= wdata_in;
                        acc     <= '0;
                        state   <= (|host_be) ? ST_RUN : ST_DONE;
                    end
                end
                ST_RUN: begin
                    if (isa_done) begin
                        pend <= pend_left;
                        if (!attr.wr) acc <= acc_nxt;
                        if (pend_left == '0) state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_steer.sv
module xbus_steer
    import xbus_steer_pkg::*;
#(
    parameter int unsigned NB = HOST_BYTES,
    localparam int unsigned OW = $clog2(NB),
    localparam int unsigned DW = NB * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             host_dev16,
    input  logic [NB-1:0]    host_be,
    input  logic [DW-1:0]    host_wdata,
    output logic             host_done,
    output logic [DW-1:0]    pci_rdata,
    input  logic             dma_req,
    input  logic             dma_wide,
    input  logic             dma_to_pci,
    input  logic [OW-1:0]    dma_lane,
    output logic             dma_done,
    output logic             isa_req,
    output logic             isa_wr,
    output logic             isa_dma,
    output logic             isa_wide,
    output logic [OW-1:0]    isa_addr,
    output logic [ISA_W-1:0] isa_wdata,
    input  logic [ISA_W-1:0] isa_rdata,
    input  logic             isa_done
);

    seq_state_e    state;
    logic [NB-1:0] pend;
    xfer_attr_t    attr;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] acc;
    logic [DW-1:0] acc_nxt;
    logic [NB-1:0] take;
    logic [OW-1:0] off;
    logic          wide;

    xbus_steer_seq #(.NB(NB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_dev16 (host_dev16),
        .host_be    (host_be),
        .dma_req    (dma_req),
        .dma_wide   (dma_wide),
        .dma_to_pci (dma_to_pci),
        .dma_lane   (dma_lane),
        .wdata_in   (host_wdata),
        .isa_done   (isa_done),
        .take       (take),
        .acc_nxt    (acc_nxt),
        .state      (state),
        .pend       (pend),
        .attr       (attr),
        .wdata_q    (wdata_q),
        .acc        (acc)
    );

    xbus_steer_pick #(.NB(NB)) u_pick (
        .pend  (pend),
        .dev16 (attr.dev16),
        .off   (off),
        .wide  (wide),
        .take  (take)
    );

    xbus_steer_lanes #(.NB(NB)) u_lanes (
        .wdata     (wdata_q),
        .off       (off),
        .wide      (wide),
        .dev16     (attr.dev16),
        .isa_rdata (isa_rdata),
        .acc       (acc),
        .isa_wdata (isa_wdata),
        .acc_nxt   (acc_nxt)
    );

    assign isa_req   = (state == ST_RUN);
    assign isa_wr    = attr.wr;
    assign isa_dma   = attr.dma;
    assign isa_wide  = wide;
    assign isa_addr  = off;
    assign host_done = (state == ST_DONE) && !attr.dma;
    assign dma_done  = (state == ST_DONE) && attr.dma;
    assign pci_rdata = acc;

endmodule

// File: rtl/xbus_steer_chk.sv
module xbus_steer_chk #(
    parameter int unsigned OW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          host_done,
    input logic          dma_done,
    input logic          isa_req,
    input logic          isa_done,
    input logic          isa_wide,
    input logic [OW-1:0] isa_addr
);

    // R8: host completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);

    // R9: DMA and host completions never coincide
    a_r9_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(host_done && dma_done));

    // R7: a sub-cycle holds its request and shape until it is completed
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (isa_req && !isa_done) |=> (isa_req && $stable(isa_addr) && $stable(isa_wide)));

    // R2: a 16-bit sub-cycle always starts on an even offset
    a_r2_wide_aligned: assert property (@(posedge clk) disable iff (rst)
        (isa_req && isa_wide) |-> !isa_addr[0]);

    // R8: no completion while a sub-cycle is still outstanding
    a_r8_quiet_busy: assert property (@(posedge clk) disable iff (rst)
        isa_req |-> (!host_done && !dma_done));

    // R3: sub-cycles of one request move strictly upward in offset
    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (isa_req && isa_done) |=> (!isa_req || (isa_addr > $past(isa_addr))));

endmodule

bind xbus_steer xbus_steer_chk #(.OW(OW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_done (host_done),
    .dma_done  (dma_done),
    .isa_req   (isa_req),
    .isa_done  (isa_done),
    .isa_wide  (isa_wide),
    .isa_addr  (isa_addr)
);

// File: tb/test_xbus_steer.sv
module test_xbus_steer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_dev16 = 1'b0;
    logic [3:0]  host_be = 4'h0;
    logic [31:0] host_wdata = 32'h0;
    logic        host_done;
    logic [31:0] pci_rdata;
    logic        dma_req = 1'b0;
    logic        dma_wide = 1'b0;
    logic        dma_to_pci = 1'b0;
    logic [1:0]  dma_lane = 2'd0;
    logic        dma_done;
    logic        isa_req;
    logic        isa_wr;
    logic        isa_dma;
    logic        isa_wide;
    logic [1:0]  isa_addr;
    logic [15:0] isa_wdata;
    logic [15:0] isa_rdata = 16'h0;
    logic        isa_done = 1'b0;

    always #2 clk = ~clk;

    xbus_steer i_xbus_steer (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_wr(host_wr), .host_dev16(host_dev16),
        .host_be(host_be), .host_wdata(host_wdata), .host_done(host_done),
        .pci_rdata(pci_rdata),
        .dma_req(dma_req), .dma_wide(dma_wide), .dma_to_pci(dma_to_pci),
        .dma_lane(dma_lane), .dma_done(dma_done),
        .isa_req(isa_req), .isa_wr(isa_wr), .isa_dma(isa_dma), .isa_wide(isa_wide),
        .isa_addr(isa_addr), .isa_wdata(isa_wdata), .isa_rdata(isa_rdata),
        .isa_done(isa_done)
    );

    int errors = 0;
    int checks = 0;
    int lat = 0;
    logic [7:0] seed = 8'h00;

    // expected sub-cycle list
    int         n_exp;
    logic [1:0] e_addr [0:7];
    logic       e_wide [0:7];
    logic       e_dma  [0:7];
    logic [15:0] e_wd  [0:7];
    // observed sub-cycle list
    int         n_log;
    logic [1:0] l_addr [0:7];
    logic       l_wide [0:7];
    logic       l_dma  [0:7];
    logic       l_wr   [0:7];
    logic [15:0] l_wd  [0:7];

    logic [31:0] exp_hr;
    logic [31:0] exp_dr;
    int          host_cycles;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mb(input int k);
        return 8'((k + 1) * 17) ^ seed;
    endfunction

    function automatic logic [7:0] wb(input int k);
        return host_wdata[k*8 +: 8];
    endfunction

    task automatic add_exp(input int a, input bit w, input bit d, input logic [15:0] wd);
        e_addr[n_exp] = 2'(a);
        e_wide[n_exp] = w;
        e_dma[n_exp]  = d;
        e_wd[n_exp]   = wd;
        n_exp++;
    endtask

    // R2 R3 R4 R5: arithmetic expectation for a host request
    task automatic plan_host();
        int k = 0;
        exp_hr = 32'h0;
        host_cycles = 0;
        for (int j = 0; j < 4; j++) if (host_be[j]) exp_hr[j*8 +: 8] = mb(j);
        while (k < 4) begin
            if (host_be[k]) begin
                if (host_dev16 && (k % 2 == 0) && host_be[k+1]) begin
                    add_exp(k, 1'b1, 1'b0, {wb(k+1), wb(k)});
                    k += 2;
                end else begin
                    if (host_dev16 && (k % 2 == 1)) add_exp(k, 1'b0, 1'b0, {wb(k), 8'h00});
                    else                            add_exp(k, 1'b0, 1'b0, {8'h00, wb(k)});
                    k++;
                end
                host_cycles++;
            end else k++;
        end
    endtask

    // R9: arithmetic expectation for a DMA item
    task automatic plan_dma();
        int a;
        exp_dr = 32'h0;
        if (dma_wide) begin
            a = int'(dma_lane) & 2;
            add_exp(a, 1'b1, 1'b1, {wb(a+1), wb(a)});
            exp_dr[a*8 +: 16] = {mb(a+1), mb(a)};
        end else begin
            a = int'(dma_lane);
            add_exp(a, 1'b0, 1'b1, {8'h00, wb(a)});
            exp_dr[a*8 +: 8] = mb(a);
        end
    endtask

    // device model response for the current sub-cycle
    function automatic logic [15:0] dev_read();
        bit dev16 = isa_dma ? dma_wide : host_dev16;
        int a = int'(isa_addr);
        if (isa_wide) return {mb(a+1), mb(a)};
        if (dev16) return (a % 2 == 1) ? {mb(a), 8'hEE} : {8'hEE, mb(a)};
        return {8'h5A, mb(a)};
    endfunction

    task automatic run(input bit hq, input bit dq);
        int cyc = 0;
        int wc = 0;
        int last_done = -10;
        bit hseen = 1'b0;
        bit dseen = 1'b0;
        n_log = 0;
        @(negedge clk);
        host_req = hq;
        dma_req = dq;
        while (!((!hq || hseen) && (!dq || dseen)) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (dma_done) begin
                dseen = 1'b1;
                dma_req = 1'b0;
                check(cyc - last_done == 1, "R8 dma done timing", 32'(cyc - last_done), 32'd1);
                if (dma_to_pci) check(pci_rdata == exp_dr, "R9 dma read word", pci_rdata, exp_dr);
            end
            if (host_done) begin
                hseen = 1'b1;
                host_req = 1'b0;
                if (host_cycles == 0) check(cyc == 1, "R8 empty enables done", 32'(cyc), 32'd1);
                else check(cyc - last_done == 1, "R8 host done timing", 32'(cyc - last_done), 32'd1);
                if (!host_wr) check(pci_rdata == exp_hr, "R6 R4 read word", pci_rdata, exp_hr);
                if (dq) check(dseen, "R10 dma before host", 32'(dseen), 32'd1);
            end
            if (isa_done) begin
                isa_done = 1'b0;
            end else if (isa_req) begin
                if (wc >= lat) begin
                    if (n_log < 8) begin
                        l_addr[n_log] = isa_addr;
                        l_wide[n_log] = isa_wide;
                        l_dma[n_log]  = isa_dma;
                        l_wr[n_log]   = isa_wr;
                        l_wd[n_log]   = isa_wdata;
                    end
                    n_log++;
                    isa_rdata = dev_read();
                    isa_done = 1'b1;
                    wc = 0;
                    last_done = cyc;
                end else wc++;
            end
        end
        check(cyc < 2000, "R8 completion reached", 32'(cyc), 32'd0);
        check(n_log == n_exp, "R2 R3 R4 sub-cycle count", 32'(n_log), 32'(n_exp));
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            check(l_addr[i] == e_addr[i], "R2 R3 R9 offset", 32'(l_addr[i]), 32'(e_addr[i]));
            check(l_wide[i] == e_wide[i], "R2 R5 width", 32'(l_wide[i]), 32'(e_wide[i]));
            check(l_dma[i] == e_dma[i], "R9 R10 dma flag", 32'(l_dma[i]), 32'(e_dma[i]));
            if (l_wr[i]) check(l_wd[i] == e_wd[i], "R3 R5 write lanes", 32'(l_wd[i]), 32'(e_wd[i]));
        end
        @(negedge clk);
        check(!host_done && !dma_done, "R8 single pulse", 32'({host_done, dma_done}), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!isa_req && !host_done && !dma_done, "R1 reset outputs",
              32'({isa_req, host_done, dma_done}), 32'd0);
        check(pci_rdata == 32'h0, "R1 reset read word", pci_rdata, 32'h0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6 R7 R8: host sweep over device width, direction and enables
        for (int d16 = 0; d16 < 2; d16++) begin
            for (int w = 0; w < 2; w++) begin
                for (int be = 0; be < 16; be++) begin
                    host_dev16 = d16[0];
                    host_wr    = w[0];
                    host_be    = 4'(be);
                    host_wdata = 32'h4433_2211 + 32'(be) * 32'h0101_0101 + 32'(d16);
                    seed       = 8'(be * 7 + d16 * 3 + w);
                    lat        = (be + w) % 3;
                    n_exp = 0;
                    plan_host();
                    run(1'b1, 1'b0);
                end
            end
        end

        // R9: DMA sweep over width, direction and lane
        for (int dw = 0; dw < 2; dw++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int ln = 0; ln < 4; ln++) begin
                    dma_wide   = dw[0];
                    dma_to_pci = dir[0];
                    dma_lane   = 2'(ln);
                    host_wdata = 32'hC3B2_A190 ^ 32'(ln * 16 + dw);
                    seed       = 8'(ln * 11 + dir);
                    lat        = ln % 2;
                    n_exp = 0;
                    plan_dma();
                    run(1'b0, 1'b1);
                end
            end
        end

        // R10: host and DMA requested in the same idle cycle
        for (int t = 0; t < 6; t++) begin
            dma_wide   = t[0];
            dma_to_pci = 1'b1;
            dma_lane   = 2'(t + 1);
            host_dev16 = t[1];
            host_wr    = 1'b0;
            host_be    = 4'(t * 5 + 3);
            host_wdata = 32'h1234_5678 + 32'(t);
            seed       = 8'(t * 13 + 1);
            lat        = t % 3;
            n_exp = 0;
            plan_dma();
            plan_host();
            run(1'b1, 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule